// File: doc/BRIEF.md
# Fault Latch and Retry Controller

This block decides whether a protected power path may stay switched on. Three qualified fault lines come in: overcurrent, overvoltage and an external cause. The block answers with one enable level for the downstream switch. The enable drops in the same cycle that any fault line is high. A registered state machine then decides how the path recovers. In latch mode the path stays off until software or a supervisor issues an explicit clear. In auto-retry mode the path first waits through a programmable hold-off and is then switched back on. After that it has to stay fault-free for a programmable stable window before normal operation is declared again.

Retries are counted, so a persistent short cannot drive the path into endless hiccup cycling. A trip that arrives once the count has reached the programmed limit parks the controller in the latched state. A sticky fault level and a two-bit source code record why the path was shut down. Both stay set until an honoured clear, so a slow supervisor never misses the event.

Top module: `fault_retry_ctrl`

## Requirements
- R1: `enable_o` is low in every cycle in which any of `ocp_i`, `ovp_i` or `ext_i` is high, whatever the state. The delay from fault input to enable output is combinational.
- R2: With `retry_mode_i` = 0 (latch mode), a trip holds `enable_o` low for as long as no honoured clear arrives. No retry is attempted and `retry_cnt_o` stays 0.
- R3: With `retry_mode_i` = 1 (auto-retry), `enable_o` rises again exactly `holdoff_cycles_i` clock edges after the edge that registered the trip, provided the fault has gone. A fault during the hold-off restarts the hold-off from zero and does not add a retry.
- R4: After re-enable, a fault inside the next `stable_cycles_i` cycles counts as a new trip: `retry_cnt_o` increments and a new hold-off starts. If `stable_cycles_i` cycles pass without a fault, the controller returns to normal and `retry_cnt_o` goes back to 0.
- R5: Each trip that starts a hold-off increments `retry_cnt_o`, and the count never exceeds `retry_limit_i`. A trip that arrives while the count equals the limit latches the controller permanently: `enable_o` stays low until an honoured clear.
- R6: `fault_o` goes high on the edge after any trip. It stays high, even after a successful auto-retry recovery, until an honoured clear.
- R7: `src_id_o` holds the source of the most recent trip, encoded as 2'b00 none, 2'b01 overcurrent, 2'b10 overvoltage, 2'b11 external. When several inputs are high together, overcurrent wins over overvoltage, and overvoltage wins over external.
- R8: `clear_i` is ignored while any fault input is high.
- R9: A clear given while no fault input is high zeros `fault_o`, `src_id_o` and `retry_cnt_o` and returns the controller to normal operation with `enable_o` high. This holds in any state.
- R10: After reset, `enable_o` is high (no fault present), `fault_o` is 0, `src_id_o` is 2'b00 and `retry_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ocp_i | input | 1 | Qualified overcurrent fault |
| ovp_i | input | 1 | Qualified overvoltage fault |
| ext_i | input | 1 | Qualified external fault |
| retry_mode_i | input | 1 | 0 latch mode, 1 auto-retry mode |
| clear_i | input | 1 | Explicit clear command |
| holdoff_cycles_i | input | CNT_W | Hold-off length in cycles |
| stable_cycles_i | input | CNT_W | Fault-free window length in cycles |
| retry_limit_i | input | RETRY_W | Maximum number of retries |
| enable_o | output | 1 | Power-path enable |
| fault_o | output | 1 | Sticky fault level |
| src_id_o | output | 2 | Source of the latest trip |
| retry_cnt_o | output | RETRY_W | Retries since last recovery or clear |

## Verification
The assertions assume the settings `holdoff_cycles_i`, `stable_cycles_i` and `retry_limit_i` are static while the controller is away from normal operation. The retry bound in particular compares the live count against the live limit. They also assume the fault and clear inputs change only between clock edges. The bench programs the settings once, before reset is released, and never touches them again. It drives every input just after a falling edge and samples every output at that same point.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_LATCHED = 2'd1,
    ST_HOLDOFF = 2'd2,
    ST_TRIAL   = 2'd3
  } frc_state_e;

  localparam logic [1:0] SRC_NONE = 2'b00;
  localparam logic [1:0] SRC_OC   = 2'b01;
  localparam logic [1:0] SRC_OV   = 2'b10;
  localparam logic [1:0] SRC_EXT  = 2'b11;

  // Fixed priority: overcurrent, then overvoltage, then external.
  function automatic logic [1:0] src_pick(input logic oc, input logic ov, input logic ex);
    if (oc)      return SRC_OC;
    else if (ov) return SRC_OV;
    else if (ex) return SRC_EXT;
    else         return SRC_NONE;
  endfunction

  // A window of len cycles ends when the elapsed count reaches len-1.
  // A zero length behaves like one cycle.
  function automatic logic window_end(input logic [31:0] elapsed, input logic [31:0] len);
    return (elapsed + 32'd1) >= len;
  endfunction

endpackage

// File: rtl/frc_src_encode.sv
module frc_src_encode
  import frc_pkg::*;
(
  input  logic       oc_i,
  input  logic       ov_i,
  input  logic       ex_i,
  output logic       any_o,
  output logic [1:0] code_o
);
  assign any_o  = oc_i | ov_i | ex_i;
  assign code_o = src_pick(oc_i, ov_i, ex_i);
endmodule

// File: rtl/frc_phase_timer.sv
module frc_phase_timer
  import frc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] elapsed_q;

  assign done_o = run_i && window_end(32'(elapsed_q), 32'(len_i));

  // The timer restarts whenever the phase pauses or ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 elapsed_q <= '0;
    else if (!run_i || done_o)  elapsed_q <= '0;
    else if (elapsed_q != CNT_MAX) elapsed_q <= elapsed_q + 1'b1;
  end
endmodule

// File: rtl/frc_retry_counter.sv
module frc_retry_counter #(
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bump_i,
  input  logic               zero_i,
  output logic [RETRY_W-1:0] cnt_o
);
  localparam logic [RETRY_W-1:0] CNT_TOP = {RETRY_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_o <= '0;
    else if (zero_i)                     cnt_o <= '0;
    else if (bump_i && cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl
  import frc_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ocp_i,
  input  logic               ovp_i,
  input  logic               ext_i,
  input  logic               retry_mode_i,
  input  logic               clear_i,
  input  logic [CNT_W-1:0]   holdoff_cycles_i,
  input  logic [CNT_W-1:0]   stable_cycles_i,
  input  logic [RETRY_W-1:0] retry_limit_i,
  output logic               enable_o,
  output logic               fault_o,
  output logic [1:0]         src_id_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  frc_state_e state_q, state_d;

  // Named events, visible to the bound checker.
  logic       trip_evt;
  logic [1:0] trip_src;
  logic       clear_ok;
  logic       on_path;
  logic       retry_go;
  logic       phase_run;
  logic       phase_done;
  logic       holdoff_done;
  logic       stable_done;
  logic [CNT_W-1:0] phase_len;

  frc_src_encode u_enc (
    .oc_i  (ocp_i),
    .ov_i  (ovp_i),
    .ex_i  (ext_i),
    .any_o (trip_evt),
    .code_o(trip_src)
  );

  assign clear_ok  = clear_i && !trip_evt;
  assign on_path   = (state_q == ST_RUN) || (state_q == ST_TRIAL);
  assign retry_go  = trip_evt && on_path && retry_mode_i && (retry_cnt_o < retry_limit_i);
  assign phase_run = ((state_q == ST_HOLDOFF) || (state_q == ST_TRIAL)) && !trip_evt;
  assign phase_len = (state_q == ST_HOLDOFF) ? holdoff_cycles_i : stable_cycles_i;

  frc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (phase_run),
    .len_i (phase_len),
    .done_o(phase_done)
  );

  assign holdoff_done = phase_done && (state_q == ST_HOLDOFF);
  assign stable_done  = phase_done && (state_q == ST_TRIAL) && !clear_ok;

  frc_retry_counter #(.RETRY_W(RETRY_W)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .bump_i(retry_go),
    .zero_i(clear_ok || stable_done),
    .cnt_o (retry_cnt_o)
  );

  always_comb begin
    state_d = state_q;
    if (trip_evt) begin
      if (on_path) state_d = retry_go ? ST_HOLDOFF : ST_LATCHED;
    end else if (clear_ok) begin
      state_d = ST_RUN;
    end else if (holdoff_done) begin
      state_d = ST_TRIAL;
    end else if (stable_done) begin
      state_d = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      fault_o  <= 1'b0;
      src_id_o <= SRC_NONE;
    end else begin
      state_q <= state_d;
      if (trip_evt) begin
        fault_o  <= 1'b1;
        src_id_o <= trip_src;
      end else if (clear_ok) begin
        fault_o  <= 1'b0;
        src_id_o <= SRC_NONE;
      end
    end
  end

  assign enable_o = on_path && !trip_evt;

endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
  parameter int RETRY_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ocp_i,
  input logic               ovp_i,
  input logic               ext_i,
  input logic               clear_i,
  input logic               enable_o,
  input logic               fault_o,
  input logic [1:0]         src_id_o,
  input logic [RETRY_W-1:0] retry_cnt_o,
  input logic [RETRY_W-1:0] retry_limit_i,
  input logic [1:0]         state_q,
  input logic               clear_ok,
  input logic               stable_done
);
  AST_EN_LOW_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_i || ovp_i || ext_i) |-> !enable_o); // R1
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 2'd1 && !clear_ok) |=> (state_q == 2'd1 && !enable_o)); // R2
  AST_HOLDOFF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 2'd2) |-> !enable_o); // R3
  AST_WINDOW_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    stable_done |=> (retry_cnt_o == '0 && state_q == 2'd0)); // R4
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt_o <= retry_limit_i); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !clear_ok) |=> fault_o); // R6
  AST_SRC_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o == (src_id_o != 2'b00))); // R7
  AST_CLEAR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && (ocp_i || ovp_i || ext_i)) |=> fault_o); // R8
  AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_ok |=> (!fault_o && retry_cnt_o == '0 && state_q == 2'd0)); // R9
endmodule

bind fault_retry_ctrl frc_checker #(.RETRY_W(RETRY_W)) u_frc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .ocp_i        (ocp_i),
  .ovp_i        (ovp_i),
  .ext_i        (ext_i),
  .clear_i      (clear_i),
  .enable_o     (enable_o),
  .fault_o      (fault_o),
  .src_id_o     (src_id_o),
  .retry_cnt_o  (retry_cnt_o),
  .retry_limit_i(retry_limit_i),
  .state_q      (state_q),
  .clear_ok     (clear_ok),
  .stable_done  (stable_done)
);

// File: tb/fault_retry_ctrl_bench.sv
`timescale 1ns/1ps
module fault_retry_ctrl_bench;
  localparam int CNT_W   = 8;
  localparam int RETRY_W = 3;
  localparam int HOLD    = 4;
  localparam int STAB    = 5;
  localparam int LIMIT   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ocp = 1'b0, ovp = 1'b0, ext = 1'b0, mode = 1'b0, clr = 1'b0;
  logic [CNT_W-1:0]   hold_len = CNT_W'(HOLD);
  logic [CNT_W-1:0]   stab_len = CNT_W'(STAB);
  logic [RETRY_W-1:0] lim      = RETRY_W'(LIMIT);
  logic en, flt;
  logic [1:0] src;
  logic [RETRY_W-1:0] rcnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fault_retry_ctrl #(.CNT_W(CNT_W), .RETRY_W(RETRY_W)) u_fault_retry_ctrl (
    .clk(clk), .rst_n(rst_n), .ocp_i(ocp), .ovp_i(ovp), .ext_i(ext),
    .retry_mode_i(mode), .clear_i(clr), .holdoff_cycles_i(hold_len),
    .stable_cycles_i(stab_len), .retry_limit_i(lim),
    .enable_o(en), .fault_o(flt), .src_id_o(src), .retry_cnt_o(rcnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R10 enable", en, 1);
    chk_eq("R10 fault", flt, 0);
    chk_eq("R10 src", src, 0);
    chk_eq("R10 retry", rcnt, 0);
  endtask

  task automatic t_latch_and_priority();
    mode = 1'b0;
    ocp = 1'b1; ovp = 1'b1; #1;
    chk_eq("R1 enable drops with fault", en, 0);
    step(1); ocp = 1'b0; ovp = 1'b0;
    chk_eq("R7 oc beats ov", src, 1);
    chk_eq("R6 fault set", flt, 1);
    step(20);
    chk_eq("R2 latch keeps off", en, 0);
    chk_eq("R2 no retry count", rcnt, 0);
    // clear while a fault is active is ignored
    ext = 1'b1; clr = 1'b1; step(1); clr = 1'b0;
    chk_eq("R8 clear ignored fault", flt, 1);
    chk_eq("R8 clear ignored enable", en, 0);
    chk_eq("R7 latest source ext", src, 3);
    ovp = 1'b1; step(1); ovp = 1'b0; ext = 1'b0;
    chk_eq("R7 ov beats ext", src, 2);
    do_clear();
    chk_eq("R9 clear fault", flt, 0);
    chk_eq("R9 clear src", src, 0);
    chk_eq("R9 clear enable", en, 1);
  endtask

  task automatic t_auto_recover();
    mode = 1'b1;
    ovp = 1'b1; #1;
    chk_eq("R1 enable drops auto", en, 0);
    step(1); ovp = 1'b0;
    chk_eq("R5 retry count 1", rcnt, 1);
    step(HOLD - 1);
    chk_eq("R3 still off at hold-off end-1", en, 0);
    step(1);
    chk_eq("R3 enable back after hold-off", en, 1);
    step(STAB - 1);
    chk_eq("R4 count kept in window", rcnt, 1);
    step(1);
    chk_eq("R4 count zero after window", rcnt, 0);
    chk_eq("R6 fault stays after recovery", flt, 1);
    do_clear();
    chk_eq("R9 clear after recovery", flt, 0);
  endtask

  task automatic t_holdoff_restart();
    mode = 1'b1;
    ocp = 1'b1; step(1); ocp = 1'b0;
    step(2);
    ext = 1'b1; step(1); ext = 1'b0;
    chk_eq("R3 no extra retry in hold-off", rcnt, 1);
    step(HOLD - 1);
    chk_eq("R3 restarted hold-off still off", en, 0);
    step(1);
    chk_eq("R3 enable after restarted hold-off", en, 1);
    step(STAB);
    chk_eq("R4 recovered", rcnt, 0);
    do_clear();
  endtask

  task automatic t_retry_cap();
    mode = 1'b1;
    ocp = 1'b1; step(1); ocp = 1'b0;
    step(HOLD);
    chk_eq("R3 first re-enable", en, 1);
    step(2);
    ovp = 1'b1; step(1); ovp = 1'b0;
    chk_eq("R4 window fault retries", rcnt, 2);
    chk_eq("R4 window fault disables", en, 0);
    step(HOLD);
    chk_eq("R3 second re-enable", en, 1);
    ext = 1'b1; step(1); ext = 1'b0;
    chk_eq("R5 count capped", rcnt, LIMIT);
    step(HOLD + STAB + 10);
    chk_eq("R5 permanently latched", en, 0);
    chk_eq("R7 cap source ext", src, 3);
    do_clear();
    chk_eq("R9 clear zeros retry", rcnt, 0);
    chk_eq("R9 clear enables", en, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_latch_and_priority();
    t_auto_recover();
    t_holdoff_restart();
    t_retry_cap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule